// File: doc/BRIEF.md
# Write-Only Serial Register Loader

This block is the receive end of a serial control port that can only be written. An external master selects the block by pulling slave select low. It then clocks serial data in, most significant bit first. When slave select returns high, the block takes the newest 32 bits it received. The upper 16 bits form a register address and the lower 16 bits form a register value. The block presents them to an internal register file as a single write. There is no serial output and no read path.

Slave select, the serial clock and the serial data come from outside the chip. Each passes through its own synchroniser into the system clock domain. All framing is then done by the system clock, which oversamples the serial lines, so the order of the three lines relative to each other is kept.

Unlimited-length transfers are accepted. Bits beyond 32 push the oldest ones out. A transfer that delivers fewer than 32 bits is dropped without any write.

Top module: `spi_wr_loader`

## Requirements
- R1: After reset, `reg_we` is 0 and `reg_addr` and `reg_data` are both 0.
- R2: A transfer of exactly 32 bits, sent MSB first and sampled on the rising serial clock edge, produces a write with `reg_addr` equal to the first 16 bits received and `reg_data` equal to the last 16 bits.
- R3: A transfer longer than 32 bits, including one far longer, writes using only the final 32 bits received; the bit counter never exceeds 32.
- R4: A transfer of fewer than 32 bits, including one with no serial clock edges at all, produces no write.
- R5: Each qualifying transfer produces exactly one write strobe, and that strobe is one system clock cycle wide.
- R6: `reg_addr` and `reg_data` change only in the cycle in which `reg_we` is high, and hold their value otherwise.
- R7: Serial clock edges while slave select is high are ignored: they neither shift data nor advance the bit count.
- R8: The bit count restarts from zero at every selection, so two short transfers never add up to a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ss_n | input | 1 | Slave select from the master, active low |
| sclk | input | 1 | Serial clock from the master; data sampled on rising edges |
| mosi | input | 1 | Serial data from the master, MSB first |
| reg_addr | output | 16 | Register-file write address |
| reg_data | output | 16 | Register-file write value |
| reg_we | output | 1 | Single-cycle register-file write strobe |

## Verification
The checker assumes a specific timing on the serial lines. Each serial clock level and each slave-select level must last several system clock cycles, so that the synchronisers see every edge. The first rising serial clock edge must also come well after slave select falls, so that it never falls in the same sampled cycle as the counter clear. The stimulus keeps half serial clock periods at five system cycles. It waits one half period between a slave-select edge and the nearest serial clock edge. It changes data only while the serial clock is low, so every sampled bit is stable for several system cycles on each side of its capture.

// File: rtl/spi_wr_pkg.sv
package spi_wr_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [CNT_W-1:0]   bitcnt_t;

  // Upper part of the frame is the address (received first).
  function automatic logic [ADDR_W-1:0] frame_addr(input frame_t f);
    return f[FRAME_W-1 -: ADDR_W];
  endfunction

  // Lower part of the frame is the value (received last).
  function automatic logic [DATA_W-1:0] frame_value(input frame_t f);
    return f[DATA_W-1:0];
  endfunction

  // Count received bits, stopping at one full frame.
  function automatic bitcnt_t count_step(input bitcnt_t c);
    if (c == bitcnt_t'(FRAME_W)) return c;
    return c + bitcnt_t'(1);
  endfunction

  // New frame after one more serial bit; oldest bit falls off the top.
  function automatic frame_t frame_push(input frame_t f, input logic b);
    return {f[FRAME_W-2:0], b};
  endfunction
endpackage

// File: rtl/spi_wr_sync.sv
module spi_wr_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_wr_edge.sv
module spi_wr_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/spi_wr_shifter.sv
module spi_wr_shifter
  import spi_wr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clear,
  input  logic    shift_en,
  input  logic    din,
  output frame_t  frame,
  output bitcnt_t bit_cnt,
  output logic    full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame   <= '0;
      bit_cnt <= '0;
    end else if (clear) begin
      bit_cnt <= '0;
    end else if (shift_en) begin
      frame   <= frame_push(frame, din);
      bit_cnt <= count_step(bit_cnt);
    end
  end

  assign full = (bit_cnt == bitcnt_t'(FRAME_W));
endmodule

// File: rtl/spi_wr_loader.sv
module spi_wr_loader
  import spi_wr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ss_n,
  input  logic              sclk,
  input  logic              mosi,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_data,
  output logic              reg_we
);
  logic [2:0] pins_s;
  logic       ss_act;
  logic       sel_edge;
  logic       desel_edge;
  logic       sclk_rise;
  logic       sclk_fall;
  logic       shift_en;
  frame_t     frame;
  bitcnt_t    bit_cnt;
  logic       frame_full;
  logic       commit;

  // ss_n idles high; sclk and mosi idle low.
  spi_wr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ss_n, sclk, mosi}), .q(pins_s)
  );

  assign ss_act = ~pins_s[2];

  spi_wr_edge #(.RST_VAL(1'b0)) u_ss_edge (
    .clk(clk), .rst_n(rst_n), .lvl(ss_act), .rise(sel_edge), .fall(desel_edge)
  );

  spi_wr_edge #(.RST_VAL(1'b0)) u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .lvl(pins_s[1]), .rise(sclk_rise), .fall(sclk_fall)
  );

  assign shift_en = sclk_rise & ss_act;

  spi_wr_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .clear(sel_edge), .shift_en(shift_en),
    .din(pins_s[0]), .frame(frame), .bit_cnt(bit_cnt), .full(frame_full)
  );

  assign commit = desel_edge & frame_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_we   <= 1'b0;
      reg_addr <= '0;
      reg_data <= '0;
    end else begin
      reg_we <= commit;
      if (commit) begin
        reg_addr <= frame_addr(frame);
        reg_data <= frame_value(frame);
      end
    end
  end

  logic unused_fall;
  assign unused_fall = sclk_fall;
endmodule

// File: rtl/spi_wr_loader_chk.sv
module spi_wr_loader_chk
  import spi_wr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ss_act,
  input logic              sel_edge,
  input logic              desel_edge,
  input frame_t            frame,
  input bitcnt_t           bit_cnt,
  input logic              frame_full,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_data,
  input logic              reg_we
);
  // R2: a full frame at deselect becomes the next-cycle write
  a_r2_write_matches_frame: assert property (@(posedge clk) disable iff (!rst_n)
    desel_edge && frame_full |=> reg_we && ({reg_addr, reg_data} == $past(frame)));

  // R3: count saturates at one frame
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= bitcnt_t'(FRAME_W));

  // R4: short frame never writes
  a_r4_short_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    desel_edge && !frame_full |=> !reg_we);

  // R5: strobe is one cycle wide
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R6: outputs hold outside a strobe
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |-> $stable(reg_addr) && $stable(reg_data));

  // R7: nothing advances while deselected
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_act |=> $stable(bit_cnt) && $stable(frame));

  // R8: selection restarts the count
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    sel_edge |=> bit_cnt == '0);
endmodule

bind spi_wr_loader spi_wr_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ss_act(ss_act), .sel_edge(sel_edge),
  .desel_edge(desel_edge), .frame(frame), .bit_cnt(bit_cnt),
  .frame_full(frame_full), .reg_addr(reg_addr), .reg_data(reg_data),
  .reg_we(reg_we)
);

// File: tb/sim_spi_wr_loader.sv
`timescale 1ns/1ps
module sim_spi_wr_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ss_n = 1'b1;
  logic        sclk = 1'b0;
  logic        mosi = 1'b0;
  logic [15:0] reg_addr;
  logic [15:0] reg_data;
  logic        reg_we;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] expq[$];
  string       tagq[$];
  logic [31:0] last_wr = '0;
  bit          prev_we = 1'b0;

  localparam int HALF = 5;   // system cycles per half serial period

  always #2 clk = ~clk;      // 250 MHz

  spi_wr_loader u0 (
    .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sclk(sclk), .mosi(mosi),
    .reg_addr(reg_addr), .reg_data(reg_data), .reg_we(reg_we)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  // Serial clock toggles with slave select held high (R7 stimulus).
  task automatic idle_clocks(input int n);
    for (int i = 0; i < n; i++) begin
      mosi = 1'b1;
      wait_clk(HALF); sclk = 1'b1;
      wait_clk(HALF); sclk = 1'b0;
    end
    mosi = 1'b0;
  endtask

  // Driver: sends the low n bits of pat MSB first, pushes expectation.
  task automatic send(input int n, input logic [127:0] pat, input string req);
    if (n >= 32) begin
      expq.push_back(pat[31:0]);
      tagq.push_back(req);
      last_wr = pat[31:0];
    end
    ss_n = 1'b0;
    wait_clk(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = pat[i];
      wait_clk(HALF); sclk = 1'b1;
      wait_clk(HALF); sclk = 1'b0;
    end
    wait_clk(HALF);
    ss_n = 1'b1;
    wait_clk(14);
    @(negedge clk);
    check(expq.size() == 0, req, "write missing after transfer",
          32'(expq.size()), 32'd0);
    check({reg_addr, reg_data} == last_wr, "R6", "outputs after transfer",
          {reg_addr, reg_data}, last_wr);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (reg_we) begin
        if (expq.size() == 0) begin
          check(1'b0, "R4", "unexpected write", {reg_addr, reg_data}, 32'd0);
        end else begin
          logic [31:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          check({reg_addr, reg_data} == e, t, "write contents",
                {reg_addr, reg_data}, e);
        end
      end
      if (reg_we && prev_we)
        check(1'b0, "R5", "strobe wider than one cycle", 32'd1, 32'd0);
      prev_we = reg_we;
    end
  end

  initial begin
    wait_clk(5);
    @(negedge clk);
    check(reg_we == 1'b0, "R1", "reset strobe", 32'(reg_we), 32'd0);
    check(reg_addr == 16'h0, "R1", "reset addr", 32'(reg_addr), 32'd0);
    check(reg_data == 16'h0, "R1", "reset data", 32'(reg_data), 32'd0);
    rst_n = 1'b1;
    wait_clk(5);

    send(32, 128'h1234_ABCD, "R2");
    send(32, 128'hFFFF_0000, "R2");
    send(32, 128'h0000_FFFF, "R2");
    send(32, 128'hA5A5_5A5A, "R5");
    send(40, 128'hEE_00C3_7E81, "R3");
    send(100, {28'h0, 36'hF_0F0F_0F0F, 64'h0123_4567_89AB_CDEF}, "R3");
    send(31, 128'h7FFF_FFFF, "R4");
    send(0, 128'h0, "R4");
    send(1, 128'h1, "R4");
    idle_clocks(20);
    send(20, 128'hFFFFF, "R7");
    send(20, 128'hABCDE, "R8");
    send(20, 128'h13579, "R8");
    idle_clocks(3);
    send(32, 128'hDEAD_BEEF, "R7");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_clk(200000);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL R5 watchdog expired: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule